// File: doc/BRIEF.md
# Two-Bit-Correcting Binary BCH Codec, 274-bit Word

This block protects a 256-bit data word with 18 check bits, forming a shortened binary BCH codeword of 274 bits over GF(2^9) (primitive polynomial x^9+x^4+1, with alpha^j standing for codeword bit j). One strobed request is either an encode or a decode. An encode returns the systematic codeword. A decode returns the repaired data, the number of bits flipped and a flag for words that cannot be repaired. All of the arithmetic for a request happens in one combinational pass, and the result is captured in output registers at the same edge that samples the request.

A single polynomial-remainder network modulo g(x) = m1(x)·m3(x) serves both directions. For an encode it divides x^18·d(x) and the remainder is the parity. For a decode it divides the received word, and the two syndromes are read from the 18-bit remainder at alpha and alpha^3. The decoder places each syndrome pair in one of four classes: clean, one error, two errors or hopeless. It then checks every valid bit position at once against a reversed locator polynomial. In that polynomial the S1·X term advances by a constant multiply-by-alpha from one position to the next, so no position needs a general multiplier.

A small state machine keeps track of what the output registers hold. The states are OS_IDLE (nothing new), OS_ENC (an encode result) and OS_DEC (a decode result). There are three transitions. Any state goes to OS_ENC when the strobe is high with mode 0. Any state goes to OS_DEC when the strobe is high with mode 1. Any state goes to OS_IDLE when the strobe is low. The output-valid strobe is high whenever the state is not OS_IDLE.

Top module: `bch_dec2_codec`

## Requirements
- R1: `out_valid` is high in the cycle that follows each clock edge where `in_valid` was sampled high, and low after every other edge. It is also low while reset is held.
- R2: When an encode is sampled (mode 0), `codeword_out[273:18]` equals `data_in` and `codeword_out[17:0]` is the parity. With that parity, the sum of alpha^j and the sum of alpha^(3j) over all set bits j of the codeword are both zero.
- R3: An encode result shows `data_out` equal to `data_in`, `num_corrected` 0 and `uncorrectable` 0. On an encode, `code_in` has no effect on any output.
- R4: When a decode is given a valid codeword, `data_out` equals bits [273:18] of that word, `codeword_out` equals the word, `num_corrected` is 0 and `uncorrectable` is 0.
- R5: When a decode is given a codeword with one flipped bit at any position from 0 to 273, the result is the original codeword on `codeword_out` and its data on `data_out`, with `num_corrected` 1 and `uncorrectable` 0.
- R6: When a decode is given a codeword with two flipped bits at any two distinct positions, the result is the original codeword and data, with `num_corrected` 2 and `uncorrectable` 0.
- R7: When `uncorrectable` is 1, `num_corrected` is 0, and `data_out` and `codeword_out` pass the received bits through unmodified.
- R8: A decode raises `uncorrectable` when S1 is zero but S3 is not. It also raises the flag when the number of locator roots found among positions 0..273 differs from the locator degree. For three flipped bits, the result either raises the flag or returns data that differs from the original. It never claims a clean repair of the original.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, one request per cycle |
| mode | input | 1 | 0 = encode `data_in`, 1 = decode `code_in` |
| data_in | input | 256 | Data word to encode |
| code_in | input | 274 | Received word to decode |
| out_valid | output | 1 | Result registers hold a new result |
| codeword_out | output | 274 | Encoded codeword, or repaired received word |
| data_out | output | 256 | Encoded data echo, or repaired data |
| num_corrected | output | 2 | Number of bits flipped by the decoder |
| uncorrectable | output | 1 | Decode could not be repaired |

## Verification
The bench builds the block with its default length, N = 274, so there are 256 data bits over a 9-bit field and 237 positions are shortened away. Directed flips land on the highest valid position 273, on position 0, and on the parity/data seam at bits 17 and 18. Roots that fall into the shortened range therefore have to be rejected instead of repaired. A three-bit pattern whose alpha powers sum to zero is found by search in the bench. It drives the decoder into the S1-zero, S3-nonzero failure class.

// File: rtl/bch_pkg.sv
`timescale 1ns/1ps
package bch_pkg;

    localparam int GF_M = 9;
    localparam int GF_Q = (1 << GF_M) - 1;
    // x^9 = x^4 + 1 : low bits of the primitive polynomial
    localparam logic [GF_M-1:0] GF_POLY_LOW = 9'h011;
    localparam int PAR_W = 2 * GF_M;

    typedef logic [GF_M-1:0] gf_t;

    typedef enum logic [1:0] {ERR_NONE, ERR_ONE, ERR_TWO, ERR_BAD} err_class_t;
    typedef enum logic [1:0] {OS_IDLE, OS_ENC, OS_DEC} out_state_t;

    function automatic gf_t gf_xa(input gf_t a);
        return {a[GF_M-2:0], 1'b0} ^ (a[GF_M-1] ? GF_POLY_LOW : '0);
    endfunction

    function automatic gf_t gf_mul(input gf_t a, input gf_t b);
        gf_t p;
        p = '0;
        for (int i = GF_M - 1; i >= 0; i--)
            p = gf_xa(p) ^ (b[i] ? a : '0);
        return p;
    endfunction

    // a^(2^M - 2) by repeated squaring
    function automatic gf_t gf_inv(input gf_t a);
        gf_t sq;
        gf_t r;
        sq = a;
        r  = gf_t'(1);
        for (int i = 1; i < GF_M; i++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

    function automatic gf_t gf_apow(input int e);
        gf_t v;
        v = gf_t'(1);
        for (int i = 0; i < (e % GF_Q); i++)
            v = gf_xa(v);
        return v;
    endfunction

    // g(x): product of (x + beta) over the conjugates of alpha and alpha^3
    function automatic logic [PAR_W:0] gen_poly();
        logic [PAR_W:0][GF_M-1:0] c;
        logic [PAR_W:0]           g;
        gf_t b;
        c    = '0;
        c[0] = gf_t'(1);
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < GF_M; k++) begin
                b = gf_apow(((2 * s + 1) << k) % GF_Q);
                for (int d = PAR_W; d >= 1; d--)
                    c[d] = c[d-1] ^ gf_mul(c[d], b);
                c[0] = gf_mul(c[0], b);
            end
        end
        for (int d = 0; d <= PAR_W; d++)
            g[d] = c[d][0];
        return g;
    endfunction

endpackage

// File: rtl/bch_rem.sv
`timescale 1ns/1ps
module bch_rem
    import bch_pkg::*;
#(
    parameter int N = 274
) (
    input  logic [N-1:0]     poly_in,
    output logic [PAR_W-1:0] rem_out
);
    localparam logic [PAR_W:0]   GEN_FULL = gen_poly();
    localparam logic [PAR_W-1:0] GEN_LOW  = GEN_FULL[PAR_W-1:0];

    always_comb begin
        logic [PAR_W-1:0] r;
        logic             fb;
        r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            fb = r[PAR_W-1];
            r  = {r[PAR_W-2:0], poly_in[i]} ^ (fb ? GEN_LOW : '0);
        end
        rem_out = r;
    end
endmodule

// File: rtl/bch_syn.sv
`timescale 1ns/1ps
module bch_syn
    import bch_pkg::*;
(
    input  logic [PAR_W-1:0] rem_in,
    output gf_t              s1,
    output gf_t              s3
);
    always_comb begin
        gf_t p1;
        gf_t p3;
        s1 = '0;
        s3 = '0;
        p1 = gf_t'(1);
        p3 = gf_t'(1);
        for (int j = 0; j < PAR_W; j++) begin
            if (rem_in[j]) begin
                s1 = s1 ^ p1;
                s3 = s3 ^ p3;
            end
            p1 = gf_xa(p1);
            p3 = gf_xa(gf_xa(gf_xa(p3)));
        end
    end
endmodule

// File: rtl/bch_keyeq.sv
`timescale 1ns/1ps
module bch_keyeq
    import bch_pkg::*;
(
    input  gf_t        s1,
    input  gf_t        s3,
    output err_class_t cls,
    output gf_t        lam0
);
    gf_t s1_sq;
    gf_t s1_cu;

    always_comb begin
        s1_sq = gf_mul(s1, s1);
        s1_cu = gf_mul(s1_sq, s1);
        lam0  = '0;
        if (s1 == '0) begin
            cls = (s3 == '0) ? ERR_NONE : ERR_BAD;
        end else if (s3 == s1_cu) begin
            cls = ERR_ONE;
        end else begin
            cls  = ERR_TWO;
            lam0 = s1_sq ^ gf_mul(s3, gf_inv(s1));
        end
    end
endmodule

// File: rtl/bch_chien.sv
`timescale 1ns/1ps
module bch_chien
    import bch_pkg::*;
#(
    parameter int N = 274
) (
    input  err_class_t cls,
    input  gf_t        s1,
    input  gf_t        lam0,
    output logic [N-1:0] flip_mask,
    output logic         fail
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] roots;

    // reversed locator: X^2 + S1*X + lam0 (two errors) or X + S1 (one)
    always_comb begin
        gf_t  x;
        gf_t  x2;
        gf_t  t;
        gf_t  v;
        logic hit;
        x = gf_t'(1);
        x2 = gf_t'(1);
        t = s1;
        roots = '0;
        for (int j = 0; j < N; j++) begin
            v   = (cls == ERR_TWO) ? (x2 ^ t ^ lam0) : (x ^ s1);
            hit = ((cls == ERR_ONE) || (cls == ERR_TWO)) && (v == '0);
            flip_mask[j] = hit;
            roots = roots + CW'(hit);
            x  = gf_xa(x);
            x2 = gf_xa(gf_xa(x2));
            t  = gf_xa(t);
        end
    end

    always_comb begin
        unique case (cls)
            ERR_NONE: fail = 1'b0;
            ERR_ONE:  fail = (roots != CW'(1));
            ERR_TWO:  fail = (roots != CW'(2));
            default:  fail = 1'b1;
        endcase
    end
endmodule

// File: rtl/bch_dec2_codec.sv
`timescale 1ns/1ps
module bch_dec2_codec
    import bch_pkg::*;
#(
    parameter int N = 274
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 mode,
    input  logic [N-PAR_W-1:0]   data_in,
    input  logic [N-1:0]         code_in,
    output logic                 out_valid,
    output logic [N-1:0]         codeword_out,
    output logic [N-PAR_W-1:0]   data_out,
    output logic [1:0]           num_corrected,
    output logic                 uncorrectable
);
    localparam int K = N - PAR_W;

    out_state_t       state_q;
    out_state_t       state_d;
    logic [N-1:0]     div_in;
    logic [PAR_W-1:0] rem;
    gf_t              s1;
    gf_t              s3;
    gf_t              lam0;
    err_class_t       cls;
    logic [N-1:0]     flip_mask;
    logic             fail;
    logic [N-1:0]     fixed;

    // one remainder network for both directions
    assign div_in = mode ? code_in : {data_in, {PAR_W{1'b0}}};

    bch_rem #(.N(N)) u_rem (.poly_in(div_in), .rem_out(rem));
    bch_syn u_syn (.rem_in(rem), .s1(s1), .s3(s3));
    bch_keyeq u_key (.s1(s1), .s3(s3), .cls(cls), .lam0(lam0));
    bch_chien #(.N(N)) u_chien (
        .cls(cls), .s1(s1), .lam0(lam0), .flip_mask(flip_mask), .fail(fail)
    );

    assign fixed = fail ? code_in : (code_in ^ flip_mask);

    always_comb begin
        unique case ({in_valid, mode})
            2'b10:   state_d = OS_ENC;
            2'b11:   state_d = OS_DEC;
            default: state_d = OS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OS_IDLE;
        else        state_q <= state_d;
    end

    assign out_valid = (state_q != OS_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            codeword_out  <= '0;
            data_out      <= '0;
            num_corrected <= '0;
            uncorrectable <= 1'b0;
        end else begin
            unique case (state_d)
                OS_ENC: begin
                    codeword_out  <= {data_in, rem};
                    data_out      <= data_in;
                    num_corrected <= 2'd0;
                    uncorrectable <= 1'b0;
                end
                OS_DEC: begin
                    codeword_out  <= fixed;
                    data_out      <= fixed[N-1:PAR_W];
                    num_corrected <= fail ? 2'd0 :
                                     (cls == ERR_ONE) ? 2'd1 :
                                     (cls == ERR_TWO) ? 2'd2 : 2'd0;
                    uncorrectable <= fail;
                end
                default: ;
            endcase
        end
    end

    logic unused_k;
    assign unused_k = (K > 0);
endmodule

// File: rtl/bch_codec_chk.sv
`timescale 1ns/1ps
module bch_codec_chk #(
    parameter int N = 274,
    parameter int P = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             mode,
    input logic [N-P-1:0]   data_in,
    input logic [N-1:0]     code_in,
    input logic             out_valid,
    input logic [N-1:0]     codeword_out,
    input logic [N-P-1:0]   data_out,
    input logic [1:0]       num_corrected,
    input logic             uncorrectable
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_ENC_SYSTEMATIC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode) |=> (codeword_out[N-1:P] == $past(data_in))); // R2
    AST_ENC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode) |=> (num_corrected == 2'd0 && !uncorrectable
                                 && data_out == $past(data_in))); // R3
    AST_FLAG_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode) |=> (!uncorrectable ||
            (codeword_out == $past(code_in) && num_corrected == 2'd0))); // R7
    AST_FLIP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode) |=> (uncorrectable ||
            $countones(codeword_out ^ $past(code_in)) == int'(num_corrected))); // R6
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (num_corrected != 2'd3)); // R5
endmodule

bind bch_dec2_codec bch_codec_chk #(.N(N), .P(bch_pkg::PAR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .data_in(data_in), .code_in(code_in), .out_valid(out_valid),
    .codeword_out(codeword_out), .data_out(data_out),
    .num_corrected(num_corrected), .uncorrectable(uncorrectable)
);

// File: tb/sim_bch_dec2_codec.sv
`timescale 1ns/1ps
module sim_bch_dec2_codec;
    localparam int NB = 274;
    localparam int KB = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            mode = 1'b0;
    logic [KB-1:0]   data_in = '0;
    logic [NB-1:0]   code_in = '0;
    logic            out_valid;
    logic [NB-1:0]   codeword_out;
    logic [KB-1:0]   data_out;
    logic [1:0]      num_corrected;
    logic            uncorrectable;

    int checks = 0;
    int errors = 0;
    int exp_t[0:510];
    int log_t[0:511];
    logic ev;

    bch_dec2_codec u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .data_in(data_in), .code_in(code_in), .out_valid(out_valid),
        .codeword_out(codeword_out), .data_out(data_out),
        .num_corrected(num_corrected), .uncorrectable(uncorrectable)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [NB-1:0] act, input logic [NB-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // reference model of the strobe pipeline, compared every cycle
    always @(posedge clk or negedge rst_n)
        if (!rst_n) ev <= 1'b0;
        else        ev <= in_valid;

    always @(negedge clk)
        if (rst_n) chk(out_valid == ev, "R1", "out_valid per cycle",
                       NB'(out_valid), NB'(ev));

    function automatic int bsyn(input logic [NB-1:0] w, input int p);
        int s = 0;
        for (int j = 0; j < NB; j++)
            if (w[j]) s = s ^ exp_t[(p * j) % 511];
        return s;
    endfunction

    function automatic logic [KB-1:0] rnd_data();
        logic [KB-1:0] d;
        for (int i = 0; i < KB / 32; i++) d[i*32 +: 32] = $urandom();
        return d;
    endfunction

    task automatic run_enc(input logic [KB-1:0] d, output logic [NB-1:0] cw);
        @(negedge clk);
        in_valid = 1'b1; mode = 1'b0; data_in = d;
        code_in = {rnd_data(), 18'h2AAAA};
        @(negedge clk);
        in_valid = 1'b0;
        chk(codeword_out[NB-1:18] == d, "R2", "data field", codeword_out, {d, 18'h0});
        chk(bsyn(codeword_out, 1) == 0 && bsyn(codeword_out, 3) == 0, "R2",
            "syndromes zero", NB'(bsyn(codeword_out, 1)), '0);
        chk(data_out == d && num_corrected == 2'd0 && !uncorrectable, "R3",
            "encode side outputs", {data_out, 15'h0, num_corrected, uncorrectable},
            {d, 18'h0});
        cw = codeword_out;
    endtask

    // nerr 0..2: expect full repair; otherwise expect flag or a wrong word
    task automatic run_dec(input logic [NB-1:0] rx, input logic [NB-1:0] orig,
                           input int nerr, input bit must_flag);
        string rq;
        @(negedge clk);
        in_valid = 1'b1; mode = 1'b1; code_in = rx; data_in = rnd_data();
        @(negedge clk);
        in_valid = 1'b0;
        if (nerr <= 2) begin
            rq = (nerr == 0) ? "R4" : (nerr == 1) ? "R5" : "R6";
            chk(codeword_out == orig, rq, "repaired word", codeword_out, orig);
            chk(data_out == orig[NB-1:18], rq, "repaired data",
                NB'(data_out), NB'(orig[NB-1:18]));
            chk(num_corrected == 2'(nerr) && !uncorrectable, rq, "count/flag",
                NB'({num_corrected, uncorrectable}), NB'({2'(nerr), 1'b0}));
        end else begin
            if (must_flag)
                chk(uncorrectable, "R8", "S1 zero S3 nonzero flag",
                    NB'(uncorrectable), NB'(1));
            if (uncorrectable)
                chk(codeword_out == rx && data_out == rx[NB-1:18] &&
                    num_corrected == 2'd0, "R7", "pass through",
                    codeword_out, rx);
            else
                chk(data_out != orig[NB-1:18], "R8", "no false clean repair",
                    NB'(data_out), NB'(orig[NB-1:18]));
        end
    endtask

    function automatic logic [NB-1:0] flip_rand(input logic [NB-1:0] w, input int n);
        int p[3];
        logic [NB-1:0] r = w;
        for (int i = 0; i < n; i++) begin
            bit dup;
            do begin
                p[i] = $urandom_range(NB - 1);
                dup = 1'b0;
                for (int k = 0; k < i; k++) if (p[k] == p[i]) dup = 1'b1;
            end while (dup);
            r[p[i]] = ~r[p[i]];
        end
        return r;
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NB-1:0] cw;
        logic [NB-1:0] rx;
        logic [KB-1:0] da;
        logic [KB-1:0] db;
        int v = 1;
        int fi = -1;
        int fj = -1;
        int fk = -1;

        for (int i = 0; i < 511; i++) begin
            exp_t[i] = v;
            log_t[v] = i;
            v = v << 1;
            if (v & 512) v = v ^ 'h211;
        end

        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "valid low in reset", NB'(out_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "valid low after reset", NB'(out_valid), '0);

        for (int it = 0; it < 12; it++) begin
            da = (it == 0) ? '0 : (it == 1) ? '1 : rnd_data();
            run_enc(da, cw);
            run_dec(cw, cw, 0, 1'b0);
            run_dec(flip_rand(cw, 1), cw, 1, 1'b0);
            run_dec(flip_rand(cw, 2), cw, 2, 1'b0);
            run_dec(flip_rand(cw, 3), cw, 3, 1'b0);
        end

        // boundary positions: ends of the shortened word and the parity seam
        run_enc(rnd_data(), cw);
        foreach (da[q]) ;
        rx = cw; rx[0]   = ~rx[0];   run_dec(rx, cw, 1, 1'b0);
        rx = cw; rx[273] = ~rx[273]; run_dec(rx, cw, 1, 1'b0);
        rx = cw; rx[17]  = ~rx[17];  run_dec(rx, cw, 1, 1'b0);
        rx = cw; rx[18]  = ~rx[18];  run_dec(rx, cw, 1, 1'b0);
        rx = cw; rx[0] = ~rx[0]; rx[273] = ~rx[273]; run_dec(rx, cw, 2, 1'b0);
        rx = cw; rx[17] = ~rx[17]; rx[18] = ~rx[18]; run_dec(rx, cw, 2, 1'b0);

        // three flips whose alpha powers cancel: S1 = 0, S3 != 0
        for (int i = 0; i < NB && fk < 0; i++)
            for (int j = i + 1; j < NB && fk < 0; j++) begin
                int k = log_t[exp_t[i] ^ exp_t[j]];
                if (k < NB && k != i && k != j) begin fi = i; fj = j; fk = k; end
            end
        if (fk >= 0) begin
            rx = cw; rx[fi] = ~rx[fi]; rx[fj] = ~rx[fj]; rx[fk] = ~rx[fk];
            chk(bsyn(rx, 3) != 0, "R8", "pattern has S3 nonzero",
                NB'(bsyn(rx, 3)), NB'(1));
            run_dec(rx, cw, 3, 1'b1);
        end

        // back-to-back encodes
        da = rnd_data(); db = rnd_data();
        @(negedge clk); in_valid = 1'b1; mode = 1'b0; data_in = da;
        @(negedge clk); data_in = db;
        chk(codeword_out[NB-1:18] == da, "R2", "first of pair",
            NB'(codeword_out[NB-1:18]), NB'(da));
        @(negedge clk); in_valid = 1'b0;
        chk(codeword_out[NB-1:18] == db, "R2", "second of pair",
            NB'(codeword_out[NB-1:18]), NB'(db));
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule